// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a compact in-order processor pipeline that runs a small 32-bit integer instruction subset: register-to-register arithmetic and logic, word load, word store and branch-on-equal. Work moves through five stages (fetch, decode with register read, execute, memory, write-back), with a register between each pair of stages. Each of those registers carries the data and the control bits that the later stages still need. The register file has two read ports and a single write port. Instruction and data storage are small word-addressed arrays inside the block. While reset is held, they are filled through a simple load port.

Every instruction class takes exactly five stages. Register writes therefore happen only in the last stage, and two instructions never compete for the one write port. The pipeline has no forwarding, no interlocks and no squashing. Software must place three unrelated instructions between a producer and its consumer, and must fill the two slots after a branch with instructions that may safely run. Debug outputs show the fetch address, the register write port and the data-memory write port. A system or a test environment can follow execution from these outputs alone.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dbg_pc` is 0 and neither write tap is active. Every stage register resets to an empty slot.
- R2: With no taken branch, the fetch address advances by 4 every cycle. The fetched word is storage entry `pc[IAW+1:2]`.
- R3: Opcode field `[31:26]` = 0x00 with `[10:6]` = 0 is an ALU operation. The operation is chosen by `[5:0]`: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). Sources are `[25:21]` and `[20:16]`, and the destination is `[15:11]`.
- R4: Every register write appears on the write tap in the fifth cycle of its instruction, 4 cycles after its fetch cycle. This holds for ALU operations and for loads alike.
- R5: Opcode 0x23 loads the data word at address `reg[25:21]` + sign-extended `[15:0]` into register `[20:16]`.
- R6: Opcode 0x2B stores `reg[20:16]` at address `reg[25:21]` + sign-extended `[15:0]`. The store appears on the data-memory tap 3 cycles after its fetch and writes no register.
- R7: Opcode 0x04 compares `reg[25:21]` with `reg[20:16]` in execute. If they are equal, the address fetched 3 cycles after the branch is (branch address + 4) + (sign-extended `[15:0]` << 2). The two instructions fetched after the branch always complete.
- R8: Register 0 reads as zero. A write to it changes nothing and does not appear on the write tap.
- R9: Any other encoding, including the all-zero word, writes no register and no memory and does not redirect fetch.
- R10: A register written in write-back is read correctly by an instruction fetched 4 cycles after the producer, that is, with three instructions between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_imem_we | input | 1 | Write `ld_data` into instruction storage at `ld_addr` |
| ld_dmem_we | input | 1 | Write `ld_data` into data storage at `ld_addr` |
| ld_addr | input | LAW | Word index for the load port |
| ld_data | input | 32 | Load port data |
| dbg_pc | output | 32 | Current fetch address |
| dbg_rf_we | output | 1 | Register write happening this cycle |
| dbg_rf_waddr | output | 5 | Register being written |
| dbg_rf_wdata | output | 32 | Value being written |
| dbg_dm_we | output | 1 | Data-memory write happening this cycle |
| dbg_dm_addr | output | 32 | Byte address of that write |
| dbg_dm_wdata | output | 32 | Data of that write |

## Verification
A wrong stage register or control bit shows up on the taps within five cycles of the fetch that caused it. It appears as a missing write, an extra write, a wrong register or value, or a write in the wrong cycle. A fault in the branch path shows up three cycles after the branch is fetched, as a wrong `dbg_pc`. The bench predicts every tap event and its exact cycle from its own instruction model and compares them one by one. Any slip in timing or content is therefore caught at the first event it affects.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OPC_ALU   = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic    use_imm;
        alu_op_e op;
        logic    is_beq;
    } ex_ctl_t;

    typedef struct packed {
        logic wr_en;
    } mem_ctl_t;

    typedef struct packed {
        logic           wr_en;
        logic           from_mem;
        logic [RAW-1:0] dst;
    } wb_ctl_t;

    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] pc4;
    } ifid_t;

    typedef struct packed {
        ctl_t            ctl;
        logic [XLEN-1:0] pc4;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] imm;
    } idex_t;

    typedef struct packed {
        mem_ctl_t        mem;
        wb_ctl_t         wb;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] store_data;
    } exmem_t;

    typedef struct packed {
        wb_ctl_t         wb;
        logic [XLEN-1:0] alu;
        logic [XLEN-1:0] mdata;
    } memwb_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        ifid_t           ifid;
        idex_t           idex;
        exmem_t          exmem;
        memwb_t          memwb;
    } pipe_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctl_t            ctl,
    output logic [RAW-1:0]  rs,
    output logic [RAW-1:0]  rt,
    output logic [XLEN-1:0] imm
);

    logic [5:0]     opc;
    logic [5:0]     fn;
    logic [RAW-1:0] rd;
    logic [4:0]     shamt;

    assign opc   = instr[31:26];
    assign fn    = instr[5:0];
    assign rs    = instr[25:21];
    assign rt    = instr[20:16];
    assign rd    = instr[15:11];
    assign shamt = instr[10:6];
    assign imm   = {{(XLEN-16){instr[15]}}, instr[15:0]};

    always_comb begin
        logic    known;
        alu_op_e op;
        ctl   = '0;
        known = 1'b1;
        op    = ALU_ADD;
        case (opc)
            OPC_ALU: begin
                case (fn)
                    FN_ADD:  op = ALU_ADD;
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: known = 1'b0;
                endcase
                if (shamt != '0) begin
                    known = 1'b0;
                end
                if (known) begin
                    ctl.ex.op    = op;
                    ctl.wb.wr_en = (rd != '0);
                    ctl.wb.dst   = rd;
                end
            end
            OPC_LOAD: begin
                ctl.ex.use_imm  = 1'b1;
                ctl.ex.op       = ALU_ADD;
                ctl.wb.wr_en    = (rt != '0);
                ctl.wb.from_mem = 1'b1;
                ctl.wb.dst      = rt;
            end
            OPC_STORE: begin
                ctl.ex.use_imm = 1'b1;
                ctl.ex.op      = ALU_ADD;
                ctl.mem.wr_en  = 1'b1;
            end
            OPC_BEQ: begin
                ctl.ex.is_beq = 1'b1;
                ctl.ex.op     = ALU_SUB;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            eq
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign eq = (a == b);

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_imem_we,
    input  logic            ld_dmem_we,
    input  logic [LAW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] dbg_pc,
    output logic            dbg_rf_we,
    output logic [RAW-1:0]  dbg_rf_waddr,
    output logic [XLEN-1:0] dbg_rf_wdata,
    output logic            dbg_dm_we,
    output logic [XLEN-1:0] dbg_dm_addr,
    output logic [XLEN-1:0] dbg_dm_wdata
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    pipe_t s_d, s_q;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    // decode stage
    ctl_t            id_ctl;
    logic [RAW-1:0]  id_rs, id_rt;
    logic [XLEN-1:0] id_imm;
    logic [XLEN-1:0] rf_a, rf_b;

    // execute stage
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_eq;
    logic            ex_taken;
    logic [XLEN-1:0] ex_target;

    // write-back stage
    logic [XLEN-1:0] wb_data;

    pipe5_decode u_dec (
        .instr (s_q.ifid.instr),
        .ctl   (id_ctl),
        .rs    (id_rs),
        .rt    (id_rt),
        .imm   (id_imm)
    );

    pipe5_regfile #(.NREG(1 << RAW), .W(XLEN)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (id_rs),
        .ra2 (id_rt),
        .rd1 (rf_a),
        .rd2 (rf_b),
        .we  (s_q.memwb.wb.wr_en),
        .wa  (s_q.memwb.wb.dst),
        .wd  (wb_data)
    );

    assign alu_b = s_q.idex.ctl.ex.use_imm ? s_q.idex.imm : s_q.idex.b;

    pipe5_alu u_alu (
        .op (s_q.idex.ctl.ex.op),
        .a  (s_q.idex.a),
        .b  (alu_b),
        .y  (alu_y),
        .eq (alu_eq)
    );

    assign ex_taken  = s_q.idex.ctl.ex.is_beq & alu_eq;
    assign ex_target = s_q.idex.pc4 + {s_q.idex.imm[XLEN-3:0], 2'b00};

    assign wb_data = s_q.memwb.wb.from_mem ? s_q.memwb.mdata : s_q.memwb.alu;

    // next-state computation for every stage register
    always_comb begin
        s_d = s_q;
        // fetch
        s_d.pc          = ex_taken ? ex_target : (s_q.pc + STEP);
        s_d.ifid.instr  = imem[s_q.pc[IAW+1:2]];
        s_d.ifid.pc4    = s_q.pc + STEP;
        // decode and register read
        s_d.idex.ctl    = id_ctl;
        s_d.idex.pc4    = s_q.ifid.pc4;
        s_d.idex.a      = rf_a;
        s_d.idex.b      = rf_b;
        s_d.idex.imm    = id_imm;
        // execute
        s_d.exmem.mem        = s_q.idex.ctl.mem;
        s_d.exmem.wb         = s_q.idex.ctl.wb;
        s_d.exmem.alu        = alu_y;
        s_d.exmem.store_data = s_q.idex.b;
        // memory
        s_d.memwb.wb    = s_q.exmem.wb;
        s_d.memwb.alu   = s_q.exmem.alu;
        s_d.memwb.mdata = dmem[s_q.exmem.alu[DAW+1:2]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_imem_we) begin
            imem[ld_addr[IAW-1:0]] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_dmem_we) begin
            dmem[ld_addr[DAW-1:0]] <= ld_data;
        end else if (!rst && s_q.exmem.mem.wr_en) begin
            dmem[s_q.exmem.alu[DAW+1:2]] <= s_q.exmem.store_data;
        end
    end

    assign dbg_pc       = s_q.pc;
    assign dbg_rf_we    = s_q.memwb.wb.wr_en;
    assign dbg_rf_waddr = s_q.memwb.wb.dst;
    assign dbg_rf_wdata = wb_data;
    assign dbg_dm_we    = s_q.exmem.mem.wr_en;
    assign dbg_dm_addr  = s_q.exmem.alu;
    assign dbg_dm_wdata = s_q.exmem.store_data;

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
    import pipe5_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] dbg_pc,
    input logic            dbg_rf_we,
    input logic [RAW-1:0]  dbg_rf_waddr,
    input logic            dbg_dm_we,
    input logic            ex_taken,
    input logic [XLEN-1:0] ex_target
);

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dbg_pc == '0) && !dbg_rf_we && !dbg_dm_we && !ex_taken);

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        !ex_taken |=> dbg_pc == $past(dbg_pc) + XLEN'(4));

    assert_branch_redirect_R7: assert property (@(posedge clk) disable iff (rst)
        ex_taken |=> dbg_pc == $past(ex_target));

    assert_zero_reg_silent_R8: assert property (@(posedge clk) disable iff (rst)
        dbg_rf_we |-> dbg_rf_waddr != '0);

    assert_store_no_regwrite_R6: assert property (@(posedge clk) disable iff (rst)
        dbg_dm_we |=> !dbg_rf_we);

endmodule

bind pipe5_core pipe5_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .dbg_pc       (dbg_pc),
    .dbg_rf_we    (dbg_rf_we),
    .dbg_rf_waddr (dbg_rf_waddr),
    .dbg_dm_we    (dbg_dm_we),
    .ex_taken     (ex_taken),
    .ex_target    (ex_target)
);

// File: tb/pipe5_core_test.sv
module pipe5_core_test;
    localparam int IW = 256;
    localparam int DW = 64;
    localparam int NPC = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] dbg_pc, dbg_rf_wdata, dbg_dm_addr, dbg_dm_wdata;
    logic        dbg_rf_we, dbg_dm_we;
    logic [4:0]  dbg_rf_waddr;

    always #5 clk = ~clk;

    pipe5_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) uut (
        .clk(clk), .rst(rst), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc),
        .dbg_rf_we(dbg_rf_we), .dbg_rf_waddr(dbg_rf_waddr), .dbg_rf_wdata(dbg_rf_wdata),
        .dbg_dm_we(dbg_dm_we), .dbg_dm_addr(dbg_dm_addr), .dbg_dm_wdata(dbg_dm_wdata)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] prog [IW];
    logic [31:0] bmem [DW];
    logic [31:0] breg [32];
    logic [31:0] exp_pc [NPC];
    int slot = 0, fc = 0;

    logic [4:0]  erf_a [256];
    logic [31:0] erf_d [256];
    int          erf_c [256];
    string       erf_t [256];
    int          n_erf = 0;
    logic [31:0] edm_a [64];
    logic [31:0] edm_d [64];
    int          edm_c [64];
    int          n_edm = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                          input logic [4:0] rs, input logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] alu_ref(input logic [5:0] fn, input logic [31:0] a,
                                            input logic [31:0] b);
        case (fn)
            6'h20:   return a + b;
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    task automatic put(input logic [31:0] w, input bit runs);
        prog[slot] = w;
        if (runs) begin
            exp_pc[fc] = 32'(slot * 4);
            fc++;
        end
        slot++;
    endtask

    task automatic push_rf(input logic [4:0] a, input logic [31:0] d, input string tag);
        erf_a[n_erf] = a; erf_d[n_erf] = d; erf_c[n_erf] = fc + 4; erf_t[n_erf] = tag;
        n_erf++;
        breg[a] = d;
    endtask

    task automatic r_op(input logic [5:0] fn, input logic [4:0] rd, input logic [4:0] rs,
                        input logic [4:0] rt, input string tag);
        logic [31:0] v;
        v = alu_ref(fn, breg[rs], breg[rt]);
        if (rd != 0) push_rf(rd, v, tag);
        put(enc_r(fn, rd, rs, rt), 1'b1);
    endtask

    task automatic lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] off,
                      input string tag);
        logic [31:0] a;
        a = breg[rs] + {{16{off[15]}}, off};
        if (rt != 0) push_rf(rt, bmem[a[7:2]], tag);
        put(enc_i(6'h23, rs, rt, off), 1'b1);
    endtask

    task automatic sw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] off);
        logic [31:0] a;
        a = breg[rs] + {{16{off[15]}}, off};
        edm_a[n_edm] = a; edm_d[n_edm] = breg[rt]; edm_c[n_edm] = fc + 3;
        n_edm++;
        bmem[a[7:2]] = breg[rt];
        put(enc_i(6'h2B, rs, rt, off), 1'b1);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) put(32'h0, 1'b1);
    endtask

    task automatic build;
        logic [5:0] fns [5];
        int cnt;
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
        for (int i = 0; i < IW; i++) prog[i] = '0;
        for (int i = 0; i < DW; i++) bmem[i] = '0;
        for (int i = 0; i < 32; i++) breg[i] = '0;
        bmem[0] = 32'd5;         bmem[1] = 32'hFFFF_FFFB;
        bmem[2] = 32'h7FFF_FFFF; bmem[3] = 32'h8000_0000;
        bmem[4] = 32'h0F0F_00FF; bmem[5] = 32'h1234_5678;
        bmem[6] = 32'hDEAD_BEEF; bmem[7] = 32'd32;
        // R5: back-to-back loads from a zero base
        for (int i = 1; i <= 8; i++) lw(5'(i), 5'd0, 16'(4 * (i - 1)), "R5");
        nops(3);
        // R3: every operation over every pair of four operands, no spacing
        cnt = 0;
        for (int i = 1; i <= 4; i++)
            for (int j = 1; j <= 4; j++)
                for (int f = 0; f < 5; f++) begin
                    r_op(fns[f], 5'(10 + (cnt % 20)), 5'(i), 5'(j), "R3");
                    cnt++;
                end
        // R8: register 0 write is dropped, then register 0 reads as zero
        r_op(6'h20, 5'd0, 5'd1, 5'd3, "R8");
        nops(3);
        r_op(6'h25, 5'd30, 5'd0, 5'd5, "R8");
        // R9: unknown function code and unknown opcode do nothing
        put(enc_r(6'h01, 5'd31, 5'd1, 5'd2), 1'b1);
        put(32'hFC00_0000 | enc_r(6'h20, 5'd31, 5'd1, 5'd2), 1'b1);
        put({6'h00, 5'd1, 5'd2, 5'd31, 5'd3, 6'h20}, 1'b1);
        // R5: negative offset from a loaded base
        lw(5'd9, 5'd8, 16'hFFF8, "R5");
        nops(3);
        // R6: stores, then loads that read them back
        sw(5'd1, 5'd0, 16'd64);
        sw(5'd2, 5'd0, 16'd68);
        sw(5'd3, 5'd0, 16'd72);
        sw(5'd4, 5'd0, 16'd76);
        sw(5'd5, 5'd0, 16'd80);
        sw(5'd9, 5'd0, 16'd84);
        sw(5'd6, 5'd8, 16'd8);
        lw(5'd11, 5'd0, 16'd64, "R6");
        lw(5'd12, 5'd0, 16'd40, "R6");
        lw(5'd13, 5'd0, 16'd84, "R6");
        nops(3);
        // R10: consumer four fetches after a load
        r_op(6'h20, 5'd14, 5'd13, 5'd1, "R10");
        // R7: branch not taken, then branch taken skipping two slots
        put(enc_i(6'h04, 5'd1, 5'd2, 16'd5), 1'b1);
        r_op(6'h22, 5'd15, 5'd2, 5'd1, "R7");
        put(enc_i(6'h04, 5'd3, 5'd3, 16'd4), 1'b1);
        r_op(6'h20, 5'd16, 5'd1, 5'd1, "R7");
        r_op(6'h24, 5'd17, 5'd5, 5'd6, "R7");
        put(enc_r(6'h20, 5'd31, 5'd1, 5'd2), 1'b0);
        put(enc_r(6'h25, 5'd31, 5'd2, 5'd3), 1'b0);
        r_op(6'h20, 5'd18, 5'd2, 5'd2, "R7");
        for (int k = fc; k < NPC; k++) exp_pc[k] = exp_pc[k - 1] + 32'd4;
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int i_rf, i_dm, run;
        build();
        run = fc + 12;
        @(negedge clk);
        for (int i = 0; i < IW; i++) begin
            ld_imem_we = 1'b1; ld_addr = 8'(i); ld_data = prog[i];
            @(negedge clk);
        end
        ld_imem_we = 1'b0;
        for (int i = 0; i < DW; i++) begin
            ld_dmem_we = 1'b1; ld_addr = 8'(i);
            ld_data = (i < 8) ? ((i == 0) ? 32'd5 : (i == 1) ? 32'hFFFF_FFFB :
                                 (i == 2) ? 32'h7FFF_FFFF : (i == 3) ? 32'h8000_0000 :
                                 (i == 4) ? 32'h0F0F_00FF : (i == 5) ? 32'h1234_5678 :
                                 (i == 6) ? 32'hDEAD_BEEF : 32'd32) : 32'd0;
            @(negedge clk);
        end
        ld_dmem_we = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(dbg_pc == 0, "R1", "pc in reset", dbg_pc, 0);
            chk(!dbg_rf_we && !dbg_dm_we, "R1", "writes in reset",
                {30'd0, dbg_rf_we, dbg_dm_we}, 0);
        end
        rst = 1'b0;
        chk(dbg_pc == 0, "R1", "pc after reset", dbg_pc, 0);
        i_rf = 0;
        i_dm = 0;
        for (int cyc = 1; cyc <= run; cyc++) begin
            @(negedge clk);
            chk(dbg_pc == exp_pc[cyc], (exp_pc[cyc] == exp_pc[cyc - 1] + 32'd4) ? "R2" : "R7",
                "fetch address", dbg_pc, exp_pc[cyc]);
            if (cyc <= 3)
                chk(!dbg_rf_we && !dbg_dm_we, "R1", "empty pipeline",
                    {30'd0, dbg_rf_we, dbg_dm_we}, 0);
            if (dbg_rf_we) begin
                if (i_rf < n_erf) begin
                    chk(dbg_rf_waddr == erf_a[i_rf], erf_t[i_rf], "write register",
                        32'(dbg_rf_waddr), 32'(erf_a[i_rf]));
                    chk(dbg_rf_wdata == erf_d[i_rf], erf_t[i_rf], "write value",
                        dbg_rf_wdata, erf_d[i_rf]);
                    chk(cyc == erf_c[i_rf], "R4", "write cycle", 32'(cyc), 32'(erf_c[i_rf]));
                end else begin
                    chk(1'b0, "R9", "unexpected register write", 32'(dbg_rf_waddr), 32'd0);
                end
                i_rf++;
            end
            if (dbg_dm_we) begin
                if (i_dm < n_edm) begin
                    chk(dbg_dm_addr == edm_a[i_dm], "R6", "store address", dbg_dm_addr, edm_a[i_dm]);
                    chk(dbg_dm_wdata == edm_d[i_dm], "R6", "store data", dbg_dm_wdata, edm_d[i_dm]);
                    chk(cyc == edm_c[i_dm], "R6", "store cycle", 32'(cyc), 32'(edm_c[i_dm]));
                end else begin
                    chk(1'b0, "R9", "unexpected store", dbg_dm_addr, 32'd0);
                end
                i_dm++;
            end
        end
        chk(i_rf == n_erf, "R9", "register write count", 32'(i_rf), 32'(n_erf));
        chk(i_dm == n_edm, "R6", "store count", 32'(i_dm), 32'(n_edm));
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule